// File: doc/BRIEF.md
# Lockable Watchdog Timer with Reset Pulse

This block is a watchdog timer for a power-management die. Software sets it up through a small register file. The registers are a 32-bit reload value written as two 16-bit halves, a control register and a lock register. Counting advances only on cycles where a one-cycle tick strobe is high. That strobe stands in for a 32768 Hz time base, so the block stays in the single `clk` domain. At that rate a 50 ms timeout needs a reload value of 1638.

The reload and control registers are protected by a key. They accept writes only after the 16-bit key 0xE551 has been written to the lock register. Any other value written there shuts them again. Reads are never blocked.

Once the timer is started, it counts down on each tick. When it runs out, it stops itself. If reset generation is enabled, it also drives a system-reset output that lasts a fixed number of ticks.

The register port is a plain write strobe with a combinational read mux. It has no back-pressure: every write is taken in the cycle its strobe is high, and `rdata` always shows the register selected by `addr`.

Top module: `wdt_lockable`

## Requirements
- R1: After reset the block is locked (lock register reads 1), the reload halves and control register read 0, and `sys_rst_o` is low.
- R2: Writing 0xE551 in bits [15:0] of a write to offset 0x20 unlocks configuration. Writing any other value there locks it. Bit 0 of the lock register reads 1 while locked and 0 while unlocked.
- R3: While locked, writes to offsets 0x0, 0x4 and 0x8 change nothing. Reads still return the held contents, and the timer does not start.
- R4: Offset 0x0 holds bits [15:0] of the reload value and offset 0x4 holds bits [31:16]. Each takes `wdata[15:0]` and reads back zero-extended.
- R5: The control register is at offset 0x8. Bit 1 is run, bit 2 is new-load and bit 3 is reset-enable. All other bits read 0.
- R6: When new-load is set, the next tick copies the 32-bit reload value into the counter and clears new-load. That tick does not count down.
- R7: While run is set and no load is pending, each tick decrements the counter. The tick that finds the counter at 1 or 0 is the expiry tick: the counter becomes 0 and run clears. A reload value N (N of at least 1) therefore expires on the Nth tick after the loading tick, and a reload value of 0 behaves as 1.
- R8: If reset-enable is set at the expiry tick, `sys_rst_o` goes high in the cycle after it. It stays high for exactly 4 further ticks and falls in the cycle after the 4th. If reset-enable is clear, expiry raises no reset.
- R9: While run is clear, ticks leave the counter unchanged. Setting run again resumes from the held count.
- R10: A control write in the same cycle as a tick overrides the tick's self-clearing of new-load and run. The tick itself acts on the control value held before that write.
- R11: Cycles without a tick change neither the counter nor the length of a reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle time-base strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
The risky coincidence is a control-register write landing in the same cycle as a tick. In that cycle the counter's self-clearing of new-load (on a load) or run (on expiry) competes with the software value. The bench provokes this by driving `wr_en` and `tick_en` on the same edge, once while a load is pending and once on the expiry tick. It judges the result in two ways: the control read-back must show the written bits, and the tick count up to the reset pulse must match a counter that acted on the pre-write control value.

// File: rtl/wdt_lock_pkg.sv
package wdt_lock_pkg;
  // register byte offsets (software-visible map)
  localparam int unsigned OFS_LOAD_LO = 'h00;
  localparam int unsigned OFS_LOAD_HI = 'h04;
  localparam int unsigned OFS_CTRL    = 'h08;
  localparam int unsigned OFS_LOCK    = 'h20;

  // control bit positions
  localparam int unsigned CB_RUN  = 1;
  localparam int unsigned CB_NEW  = 2;
  localparam int unsigned CB_RSTE = 3;

  typedef struct packed {
    logic rst_en;
    logic new_ld;
    logic run;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_lock_regs.sv
module wdt_lock_regs
  import wdt_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = 16,
  parameter logic [15:0] KEY    = 16'hE551
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                load_taken,
  input  logic                expired,
  output logic [DATA_W-1:0]   rdata,
  output logic [2*HALF_W-1:0] load_val,
  output wdt_ctrl_t           ctrl
);
  localparam int unsigned KEY_W = 16;

  logic              locked;
  logic [HALF_W-1:0] lo_q, hi_q;
  logic              hit_lo, hit_hi, hit_ctrl, hit_lock;
  logic              cfg_we;

  assign hit_lo   = (addr == ADDR_W'(OFS_LOAD_LO));
  assign hit_hi   = (addr == ADDR_W'(OFS_LOAD_HI));
  assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign hit_lock = (addr == ADDR_W'(OFS_LOCK));
  assign cfg_we   = wr_en && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
    end else if (wr_en && hit_lock) begin
      locked <= (wdata[KEY_W-1:0] != KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cfg_we && hit_lo) lo_q <= wdata[HALF_W-1:0];
      if (cfg_we && hit_hi) hi_q <= wdata[HALF_W-1:0];
    end
  end

  // software write wins over the counter's self-clearing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (cfg_we && hit_ctrl) begin
      ctrl.run    <= wdata[CB_RUN];
      ctrl.new_ld <= wdata[CB_NEW];
      ctrl.rst_en <= wdata[CB_RSTE];
    end else begin
      if (load_taken) ctrl.new_ld <= 1'b0;
      if (expired)    ctrl.run    <= 1'b0;
    end
  end

  assign load_val = {hi_q, lo_q};

  always_comb begin
    rdata = '0;
    unique case (1'b1)
      hit_lo:   rdata = DATA_W'(lo_q);
      hit_hi:   rdata = DATA_W'(hi_q);
      hit_ctrl: begin
        rdata[CB_RUN]  = ctrl.run;
        rdata[CB_NEW]  = ctrl.new_ld;
        rdata[CB_RSTE] = ctrl.rst_en;
      end
      hit_lock: rdata = DATA_W'(locked);
      default:  rdata = '0;
    endcase
  end

  // R2
  key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_lock && wdata[KEY_W-1:0] == KEY) |=> !locked);
  // R2
  bad_key_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_lock && wdata[KEY_W-1:0] != KEY) |=> locked);
  // R3
  locked_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && hit_ctrl && !load_taken && !expired) |=> ctrl == $past(ctrl));
  // R3
  locked_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked) |=> load_val == $past(load_val));
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core
  import wdt_lock_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  wdt_ctrl_t        ctrl,
  input  logic [CNT_W-1:0] load_val,
  output logic             load_taken,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end     = (cnt_q <= CNT_W'(1));
  assign load_taken = tick_en && ctrl.new_ld;
  assign expired    = tick_en && !ctrl.new_ld && ctrl.run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      if (ctrl.new_ld)  cnt_q <= load_val;
      else if (ctrl.run) cnt_q <= at_end ? '0 : cnt_q - CNT_W'(1);
    end
  end

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
  // R6
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && ctrl.new_ld) |=> cnt_q == $past(load_val));
  // R9
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !ctrl.new_ld) |=> $stable(cnt_q));
  // R7
  expire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> cnt_q == '0);
endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
  parameter int unsigned PULSE_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic fire,
  output logic sys_rst
);
  localparam int unsigned PW = $clog2(PULSE_TICKS + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (fire) begin
      left_q <= PW'(PULSE_TICKS);
    end else if (tick_en && left_q != '0) begin
      left_q <= left_q - PW'(1);
    end
  end

  assign sys_rst = (left_q != '0);

  // R8
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(fire));
  // R11
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !fire) |=> $stable(left_q));
endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
  import wdt_lock_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned HALF_W      = 16,
  parameter int unsigned PULSE_TICKS = 4,
  parameter logic [15:0] KEY         = 16'hE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sys_rst_o
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  wdt_ctrl_t        ctrl;
  logic [CNT_W-1:0] load_val;
  logic             load_taken, expired, fire;

  wdt_lock_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_W(HALF_W), .KEY(KEY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .load_taken(load_taken), .expired(expired),
    .rdata(rdata), .load_val(load_val), .ctrl(ctrl)
  );

  wdt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl(ctrl),
    .load_val(load_val), .load_taken(load_taken), .expired(expired)
  );

  assign fire = expired && ctrl.rst_en;

  wdt_rst_stretch #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .fire(fire),
    .sys_rst(sys_rst_o)
  );

  // R8
  no_rst_without_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !ctrl.rst_en && !sys_rst_o) |=> !sys_rst_o);
endmodule

// File: tb/wdt_lockable_test.sv
`timescale 1ns/1ps
module wdt_lockable_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_rst_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_LO = 8'h00, A_HI = 8'h04, A_CT = 8'h08, A_LK = 8'h20;

  always #2.5 clk = ~clk;

  wdt_lockable uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .sys_rst_o(sys_rst_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #0.5;
    chk(tag, rdata, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic collide_ctrl(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; tick_en = 1'b1; addr = A_CT; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic t_reset;
    rd(A_LK, 32'h1, "R1 lock after reset");
    rd(A_LO, 32'h0, "R1 load lo after reset");
    rd(A_HI, 32'h0, "R1 load hi after reset");
    rd(A_CT, 32'h0, "R1 ctrl after reset");
    chk("R1 sys_rst after reset", sys_rst_o, 0);
  endtask

  task automatic t_lock;
    wr(A_LK, 32'h0000_E551);
    rd(A_LK, 32'h0, "R2 key unlocks");
    wr(A_LK, 32'h0000_E550);
    rd(A_LK, 32'h1, "R2 wrong key locks");
    wr(A_LK, 32'hFFFF_E551);
    rd(A_LK, 32'h0, "R2 only low 16 bits compared");
  endtask

  task automatic t_regs;
    wr(A_LO, 32'hABCD_1234);
    rd(A_LO, 32'h1234, "R4 low half");
    wr(A_HI, 32'h0000_BEEF);
    rd(A_HI, 32'hBEEF, "R4 high half");
    wr(A_CT, 32'hFFFF_FFFF);
    rd(A_CT, 32'hE, "R5 ctrl only bits 1..3");
    wr(A_CT, 32'h0);
    rd(A_CT, 32'h0, "R5 ctrl cleared");
  endtask

  task automatic t_locked;
    wr(A_LK, 32'h0);
    wr(A_LO, 32'h5555);
    rd(A_LO, 32'h1234, "R3 locked load write ignored");
    wr(A_CT, 32'hE);
    rd(A_CT, 32'h0, "R3 locked ctrl write ignored");
    tick(3);
    chk("R3 no reset when locked", sys_rst_o, 0);
    wr(A_LK, 32'hE551);
  endtask

  task automatic t_expire;
    wr(A_LO, 32'd5); wr(A_HI, 32'd0);
    wr(A_CT, 32'hE);
    tick(1);
    rd(A_CT, 32'hA, "R6 new-load self-clears");
    tick(4);
    chk("R7 not expired before tick 5", sys_rst_o, 0);
    tick(1);
    chk("R7 expiry on 5th tick", sys_rst_o, 1);
    rd(A_CT, 32'h8, "R7 run clears at expiry");
    repeat (6) @(negedge clk);
    chk("R11 idle cycles keep pulse", sys_rst_o, 1);
    tick(3);
    chk("R8 pulse still high after 3 ticks", sys_rst_o, 1);
    tick(1);
    chk("R8 pulse ends after 4 ticks", sys_rst_o, 0);
    wr(A_LO, 32'd0);
    wr(A_CT, 32'hE);
    tick(1);
    chk("R7 zero load not yet expired", sys_rst_o, 0);
    tick(1);
    chk("R7 zero load acts as one", sys_rst_o, 1);
    tick(4);
    chk("R8 zero-load pulse ends", sys_rst_o, 0);
  endtask

  task automatic t_norst;
    wr(A_LO, 32'd2);
    wr(A_CT, 32'h6);
    tick(3);
    chk("R8 no reset without enable", sys_rst_o, 0);
    rd(A_CT, 32'h0, "R7 run clears without reset");
    tick(2);
    chk("R8 still no reset", sys_rst_o, 0);
  endtask

  task automatic t_hold;
    wr(A_LO, 32'd5);
    wr(A_CT, 32'hE);
    tick(3);
    wr(A_CT, 32'h8);
    tick(6);
    chk("R9 stopped counter no expiry", sys_rst_o, 0);
    rd(A_CT, 32'h8, "R9 ctrl stays stopped");
    wr(A_CT, 32'hA);
    tick(2);
    chk("R9 resumed count not yet out", sys_rst_o, 0);
    tick(1);
    chk("R9 resumed from held count", sys_rst_o, 1);
    tick(4);
  endtask

  task automatic t_collide;
    wr(A_LO, 32'd3);
    wr(A_CT, 32'hE);
    collide_ctrl(32'hE);
    rd(A_CT, 32'hE, "R10 write beats new-load clear");
    tick(1);
    rd(A_CT, 32'hA, "R10 reload tick clears new-load");
    tick(2);
    chk("R10 count from reload not out", sys_rst_o, 0);
    tick(1);
    chk("R10 expiry after reload", sys_rst_o, 1);
    tick(4);
    chk("R10 pulse cleared", sys_rst_o, 0);
    wr(A_LO, 32'd2);
    wr(A_CT, 32'hE);
    tick(2);
    collide_ctrl(32'hA);
    chk("R10 expiry uses pre-write ctrl", sys_rst_o, 1);
    rd(A_CT, 32'hA, "R10 write beats run clear");
    wr(A_CT, 32'h0);
    tick(4);
    chk("R10 pulse ends", sys_rst_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_regs();
    t_locked();
    t_expire();
    t_norst();
    t_hold();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule